// File: doc/BRIEF.md
# Pin-Function Configuration Register Bank

This block holds the configuration registers of a multi-function peripheral chip. The host reaches them through two ports. A write to the pointer port chooses a register number. Reads and writes on the value port then reach the register that the pointer selects. Two registers are implemented. The pin-function register (number 3) decides what several shared pins do. The parallel-port register (number 4) controls the enhanced parallel port: its enable, its protocol version and the style of its interrupt.

Every pin-function output is decoded combinationally from the register flops, so a new setting takes effect on the clock edge that writes it. The decoded outputs cover the following:
- whether two pins sense the media type or drive the data rate;
- whether IDE DMA is allowed;
- whether the printer/floppy multiplexer is enabled, driven or floated;
- the zero-wait-state and ready pin options;
- an exchange of the drive-select and motor lines between floppy drives 0 and 1.

The data-rate bit is loaded from a strap input on every cycle that reset is asserted. The floppy, parallel-port and IDE engines that use these selects live outside this block.

Top module: `cfgpin_ctrl`

## Requirements
- R1: A write with `host_port_i`=0 stores the pointer, and a read on that port returns it. With `host_port_i`=1, pointer 3 reaches the pin-function register and pointer 4 reaches the parallel-port register. Any other pointer reads as 0x00 and ignores writes.
- R2: On every clock with `rst_i` high, the pointer and the parallel-port register clear to zero. Pin-function bits 7..1 also clear, and bit 0 takes the value of `strap_rate_i`. After reset the strap has no effect.
- R3: In the parallel-port register only bits 0, 1 and 4 (mask 0x13) are writable. Every other bit reads back 0.
- R4: When pin-function bit 0 is 0, `media_sense_o` follows `media_pin_i` and `rate_pin_oe_o`=0 with `rate_pin_o`=0. When bit 0 is 1, `media_sense_o`=0, `rate_pin_oe_o`=1 and `rate_pin_o` follows `rate_val_i`.
- R5: Pin-function bit 1 drives `ide_dma_en_o`. When bit 1 is 1, `ide_present_o` is forced to 1. When bit 1 is 0, it follows `ide_present_pin_i`.
- R6: Pin-function bit 2 drives `pmux_en_o`. Both `pmux_oe_o` and `pmux_pullup_en_o` are 1 only when bit 2 is 1 and bit 3 (float) is 0.
- R7: When pin-function bit 4 is 0, `drv_sel_o` and `drv_mtr_o` equal `dor_sel_i` and `dor_mtr_i`. When bit 4 is 1, bit 0 and bit 1 are exchanged on both outputs.
- R8: `zws_pull_low_o`=1 only when bit 5 is 1, bit 6 is 0 and `port_short_ok_i`=1. `zws_pin_alt_o` equals bit 6.
- R9: `rdy_pin_alt_o` equals bit 7. `rdy_pull_low_o`=1 only when bit 7 is 0 and `port_extend_i`=1.
- R10: Parallel-port bit 0 drives `par_en_o`, and bit 1 drives `par_ver_o`. `par_acc_o` passes `par_acc_i` only when bit 0 is 1, so a host access to a disabled port is ignored.
- R11: `par_irq_o` is registered and rises one cycle after `par_evt_i`. When parallel-port bit 4 is 0, it stays high for exactly one cycle per event cycle. When bit 4 is 1, it holds high until a cycle with `par_clr_i`=1 and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| strap_rate_i | input | 1 | Strap sampled into pin-function bit 0 during reset |
| host_port_i | input | 1 | 0 = pointer port, 1 = value port |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for the selected port |
| media_pin_i | input | 2 | Media-sense pin levels |
| rate_val_i | input | 2 | Data-rate value from the floppy engine |
| media_sense_o | output | 2 | Media-sense values passed inward |
| rate_pin_o | output | 2 | Data-rate pin values |
| rate_pin_oe_o | output | 1 | Output enable of the data-rate pins |
| ide_present_pin_i | input | 1 | IDE-present pin level |
| ide_dma_en_o | output | 1 | IDE DMA enable |
| ide_present_o | output | 1 | IDE-present value used inside the chip |
| pmux_en_o | output | 1 | Printer/floppy multiplexer enable |
| pmux_oe_o | output | 1 | Multiplexer pin drive enable |
| pmux_pullup_en_o | output | 1 | Multiplexer pull-up enable |
| dor_sel_i | input | 2 | Drive-select bits from the digital output register |
| dor_mtr_i | input | 2 | Motor bits from the digital output register |
| drv_sel_o | output | 2 | Physical drive-select pins |
| drv_mtr_o | output | 2 | Physical motor pins |
| port_short_ok_i | input | 1 | Parallel port can take a short host cycle |
| zws_pull_low_o | output | 1 | Pull the zero-wait-state pin low |
| zws_pin_alt_o | output | 1 | Zero-wait-state pin used for power-down/chip-select |
| port_extend_i | input | 1 | Parallel port needs the host cycle extended |
| rdy_pull_low_o | output | 1 | Pull the ready pin low |
| rdy_pin_alt_o | output | 1 | Ready pin used for the encoding-select function |
| par_acc_i | input | 1 | Host access to the parallel-port registers |
| par_acc_o | output | 1 | Access forwarded to the parallel port |
| par_en_o | output | 1 | Enhanced parallel port enable |
| par_ver_o | output | 1 | Parallel-port protocol version select |
| par_evt_i | input | 1 | Parallel-port interrupt event |
| par_clr_i | input | 1 | Clear for the held interrupt |
| par_irq_o | output | 1 | Parallel-port interrupt |

## Verification
Most of the state in this block is register bits that feed combinational pin decoders. A stored bit that is wrong, stuck or misplaced therefore shows on a pin output, or in the value-port readback, by the negative edge after the write. The bench sweeps all 256 pin-function values and drives a spread of pin inputs under each one, so every decoder term is exercised against each register bit. Interrupt state is the only sequential output path. A wrong hold or clear shows one cycle after the event or the clear, and the bench walks both interrupt styles cycle by cycle.

// File: rtl/cfgpin_pkg.sv
package cfgpin_pkg;

    localparam int REG_W     = 8;
    localparam int IDX_W     = 8;
    localparam int FUNC_IDX  = 3;
    localparam int PPRT_IDX  = 4;
    localparam int DRIVES    = 2;
    localparam int RATE_W    = 2;
    localparam int MEDIA_W   = 2;

    localparam logic [REG_W-1:0] PPRT_WMASK = 8'h13;

    // Pin-function register, bit 0 at the bottom
    typedef struct packed {
        logic ready_alt;
        logic zws_alt;
        logic zws_en;
        logic swap;
        logic pmux_float;
        logic pmux_en;
        logic ide_dma;
        logic rate_out;
    } func_reg_t;

    // Parallel-port register
    typedef struct packed {
        logic [2:0] rsvd_hi;
        logic       irq_level;
        logic [1:0] rsvd_mid;
        logic       ver;
        logic       en;
    } pprt_reg_t;

    typedef enum logic {
        PORT_PTR = 1'b0,
        PORT_VAL = 1'b1
    } host_port_e;

    function automatic pprt_reg_t pprt_from_bus(input logic [REG_W-1:0] d);
        return pprt_reg_t'(d & PPRT_WMASK);
    endfunction

    function automatic func_reg_t func_reset(input logic strap);
        func_reg_t r;
        r          = '0;
        r.rate_out = strap;
        return r;
    endfunction

    // Physical slot that takes logical line d
    function automatic int unsigned drive_src(input int unsigned d, input logic swap);
        if (swap && d < 2)
            return 1 - d;
        return d;
    endfunction

endpackage

// File: rtl/cfgpin_regfile.sv
module cfgpin_regfile
    import cfgpin_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               strap_i,
    input  logic               host_port_i,
    input  logic               host_wr_i,
    input  logic [REG_W-1:0]   host_wdata_i,
    output logic [REG_W-1:0]   host_rdata_o,
    output func_reg_t          func_o,
    output logic               par_en_o,
    output logic               par_ver_o,
    output logic               irq_level_o
);

    localparam logic [IDX_W-1:0] FUNC_SEL = IDX_W'(FUNC_IDX);
    localparam logic [IDX_W-1:0] PPRT_SEL = IDX_W'(PPRT_IDX);

    logic [IDX_W-1:0] idx_q;
    func_reg_t        func_q;
    pprt_reg_t        pprt_q;
    host_port_e       port_sel;

    assign port_sel = host_port_e'(host_port_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            idx_q  <= '0;
            func_q <= func_reset(strap_i);
            pprt_q <= '0;
        end else if (host_wr_i) begin
            if (port_sel == PORT_PTR) begin
                idx_q <= IDX_W'(host_wdata_i);
            end else begin
                case (idx_q)
                    FUNC_SEL: func_q <= func_reg_t'(host_wdata_i);
                    PPRT_SEL: pprt_q <= pprt_from_bus(host_wdata_i);
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        host_rdata_o = '0;
        if (port_sel == PORT_PTR) begin
            host_rdata_o = REG_W'(idx_q);
        end else begin
            case (idx_q)
                FUNC_SEL: host_rdata_o = func_q;
                PPRT_SEL: host_rdata_o = pprt_q;
                default:  host_rdata_o = '0;
            endcase
        end
    end

    assign func_o      = func_q;
    assign par_en_o    = pprt_q.en;
    assign par_ver_o   = pprt_q.ver;
    assign irq_level_o = pprt_q.irq_level;

    // R2
    func_rst_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (func_q[REG_W-1:1] == '0 && func_q[0] == $past(strap_i)
                          && pprt_q == '0 && idx_q == '0));

    // R1
    other_idx_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (host_wr_i && host_port_i && idx_q != FUNC_SEL) |=> $stable(func_q));

    // R3
    pprt_rsvd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (host_port_i && idx_q == PPRT_SEL) |-> ((host_rdata_o & ~PPRT_WMASK) == '0));

endmodule

// File: rtl/cfgpin_pinmux.sv
module cfgpin_pinmux
    import cfgpin_pkg::*;
(
    input  func_reg_t           func_i,
    input  logic                par_en_i,
    input  logic [MEDIA_W-1:0]  media_pin_i,
    input  logic [RATE_W-1:0]   rate_val_i,
    output logic [MEDIA_W-1:0]  media_sense_o,
    output logic [RATE_W-1:0]   rate_pin_o,
    output logic                rate_pin_oe_o,
    input  logic                ide_present_pin_i,
    output logic                ide_dma_en_o,
    output logic                ide_present_o,
    output logic                pmux_en_o,
    output logic                pmux_oe_o,
    output logic                pmux_pullup_en_o,
    input  logic [DRIVES-1:0]   dor_sel_i,
    input  logic [DRIVES-1:0]   dor_mtr_i,
    output logic [DRIVES-1:0]   drv_sel_o,
    output logic [DRIVES-1:0]   drv_mtr_o,
    input  logic                port_short_ok_i,
    output logic                zws_pull_low_o,
    output logic                zws_pin_alt_o,
    input  logic                port_extend_i,
    output logic                rdy_pull_low_o,
    output logic                rdy_pin_alt_o,
    input  logic                par_acc_i,
    output logic                par_acc_o
);

    // Media sense versus data rate
    assign media_sense_o = func_i.rate_out ? '0 : media_pin_i;
    assign rate_pin_o    = func_i.rate_out ? rate_val_i : '0;
    assign rate_pin_oe_o = func_i.rate_out;

    // IDE DMA
    assign ide_dma_en_o  = func_i.ide_dma;
    assign ide_present_o = func_i.ide_dma | ide_present_pin_i;

    // Printer/floppy multiplexer
    logic pmux_drive;
    assign pmux_drive       = func_i.pmux_en & ~func_i.pmux_float;
    assign pmux_en_o        = func_i.pmux_en;
    assign pmux_oe_o        = pmux_drive;
    assign pmux_pullup_en_o = pmux_drive;

    // Drive exchange
    for (genvar d = 0; d < DRIVES; d++) begin : g_drive
        localparam int unsigned SW = drive_src(d, 1'b1);
        assign drv_sel_o[d] = func_i.swap ? dor_sel_i[SW] : dor_sel_i[d];
        assign drv_mtr_o[d] = func_i.swap ? dor_mtr_i[SW] : dor_mtr_i[d];
    end

    // Zero-wait-state pin
    assign zws_pin_alt_o  = func_i.zws_alt;
    assign zws_pull_low_o = func_i.zws_en & ~func_i.zws_alt & port_short_ok_i;

    // Ready pin
    assign rdy_pin_alt_o  = func_i.ready_alt;
    assign rdy_pull_low_o = ~func_i.ready_alt & port_extend_i;

    // Parallel-port access gate
    assign par_acc_o = par_acc_i & par_en_i;

endmodule

// File: rtl/cfgpin_irq.sv
module cfgpin_irq (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    input  logic evt_i,
    input  logic clr_i,
    output logic irq_o
);

    logic irq_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)
            irq_q <= 1'b0;
        else if (level_i)
            irq_q <= evt_i | (irq_q & ~clr_i);
        else
            irq_q <= evt_i;
    end

    assign irq_o = irq_q;

    // R11
    irq_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!level_i && !evt_i) |=> !irq_o);

    // R11
    irq_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_i && irq_o && !clr_i) |=> irq_o);

    // R11
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_i |=> irq_o);

endmodule

// File: rtl/cfgpin_ctrl.sv
module cfgpin_ctrl
    import cfgpin_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        strap_rate_i,
    input  logic        host_port_i,
    input  logic        host_wr_i,
    input  logic [7:0]  host_wdata_i,
    output logic [7:0]  host_rdata_o,
    input  logic [1:0]  media_pin_i,
    input  logic [1:0]  rate_val_i,
    output logic [1:0]  media_sense_o,
    output logic [1:0]  rate_pin_o,
    output logic        rate_pin_oe_o,
    input  logic        ide_present_pin_i,
    output logic        ide_dma_en_o,
    output logic        ide_present_o,
    output logic        pmux_en_o,
    output logic        pmux_oe_o,
    output logic        pmux_pullup_en_o,
    input  logic [1:0]  dor_sel_i,
    input  logic [1:0]  dor_mtr_i,
    output logic [1:0]  drv_sel_o,
    output logic [1:0]  drv_mtr_o,
    input  logic        port_short_ok_i,
    output logic        zws_pull_low_o,
    output logic        zws_pin_alt_o,
    input  logic        port_extend_i,
    output logic        rdy_pull_low_o,
    output logic        rdy_pin_alt_o,
    input  logic        par_acc_i,
    output logic        par_acc_o,
    output logic        par_en_o,
    output logic        par_ver_o,
    input  logic        par_evt_i,
    input  logic        par_clr_i,
    output logic        par_irq_o
);

    func_reg_t func_w;
    logic      par_en_w;
    logic      irq_level_w;

    cfgpin_regfile u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .strap_i      (strap_rate_i),
        .host_port_i  (host_port_i),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .host_rdata_o (host_rdata_o),
        .func_o       (func_w),
        .par_en_o     (par_en_w),
        .par_ver_o    (par_ver_o),
        .irq_level_o  (irq_level_w)
    );

    assign par_en_o = par_en_w;

    cfgpin_pinmux u_mux (
        .func_i            (func_w),
        .par_en_i          (par_en_w),
        .media_pin_i       (media_pin_i),
        .rate_val_i        (rate_val_i),
        .media_sense_o     (media_sense_o),
        .rate_pin_o        (rate_pin_o),
        .rate_pin_oe_o     (rate_pin_oe_o),
        .ide_present_pin_i (ide_present_pin_i),
        .ide_dma_en_o      (ide_dma_en_o),
        .ide_present_o     (ide_present_o),
        .pmux_en_o         (pmux_en_o),
        .pmux_oe_o         (pmux_oe_o),
        .pmux_pullup_en_o  (pmux_pullup_en_o),
        .dor_sel_i         (dor_sel_i),
        .dor_mtr_i         (dor_mtr_i),
        .drv_sel_o         (drv_sel_o),
        .drv_mtr_o         (drv_mtr_o),
        .port_short_ok_i   (port_short_ok_i),
        .zws_pull_low_o    (zws_pull_low_o),
        .zws_pin_alt_o     (zws_pin_alt_o),
        .port_extend_i     (port_extend_i),
        .rdy_pull_low_o    (rdy_pull_low_o),
        .rdy_pin_alt_o     (rdy_pin_alt_o),
        .par_acc_i         (par_acc_i),
        .par_acc_o         (par_acc_o)
    );

    cfgpin_irq u_irq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (irq_level_w),
        .evt_i   (par_evt_i),
        .clr_i   (par_clr_i),
        .irq_o   (par_irq_o)
    );

    // R7
    swap_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(drv_sel_o) == $countones(dor_sel_i))
        && ($countones(drv_mtr_o) == $countones(dor_mtr_i)));

    // R8
    zws_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        zws_pull_low_o |-> (port_short_ok_i && !zws_pin_alt_o));

    // R10
    par_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        par_acc_o |-> (par_acc_i && par_en_o));

endmodule

// File: tb/tb_cfgpin_ctrl.sv
module tb_cfgpin_ctrl;

    logic       clk = 1'b0;
    logic       rst;
    logic       strap;
    logic       hport, hwr;
    logic [7:0] hwdata, hrdata;
    logic [1:0] media, rate, msense, rpin;
    logic       roe, idep, idma, ipres, pen, poe, ppu;
    logic [1:0] dsel, dmtr, osel, omtr;
    logic       sok, zlow, zalt, ext, rlow, ralt;
    logic       pacc, pacc_o, paren, parver, evt, clr, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cfgpin_ctrl dut (
        .clk_i(clk), .rst_i(rst), .strap_rate_i(strap),
        .host_port_i(hport), .host_wr_i(hwr), .host_wdata_i(hwdata), .host_rdata_o(hrdata),
        .media_pin_i(media), .rate_val_i(rate), .media_sense_o(msense),
        .rate_pin_o(rpin), .rate_pin_oe_o(roe),
        .ide_present_pin_i(idep), .ide_dma_en_o(idma), .ide_present_o(ipres),
        .pmux_en_o(pen), .pmux_oe_o(poe), .pmux_pullup_en_o(ppu),
        .dor_sel_i(dsel), .dor_mtr_i(dmtr), .drv_sel_o(osel), .drv_mtr_o(omtr),
        .port_short_ok_i(sok), .zws_pull_low_o(zlow), .zws_pin_alt_o(zalt),
        .port_extend_i(ext), .rdy_pull_low_o(rlow), .rdy_pin_alt_o(ralt),
        .par_acc_i(pacc), .par_acc_o(pacc_o), .par_en_o(paren), .par_ver_o(parver),
        .par_evt_i(evt), .par_clr_i(clr), .par_irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        hport = port; hwr = 1'b1; hwdata = d;
        @(negedge clk);
        hwr = 1'b0;
    endtask

    task automatic rd(input logic port, output logic [7:0] d);
        @(negedge clk);
        hport = port; hwr = 1'b0;
        #1 d = hrdata;
    endtask

    task automatic put(input int idx, input logic [7:0] d);
        wr(1'b0, 8'(idx));
        wr(1'b1, d);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst = 1'b1; strap = s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        hport = 0; hwr = 0; hwdata = 0; media = 0; rate = 0; idep = 0;
        dsel = 0; dmtr = 0; sok = 0; ext = 0; pacc = 0; evt = 0; clr = 0;
        rst = 1; strap = 1;

        // R2: reset with strap high
        do_reset(1'b1);
        rd(1'b0, r); chk("R2 pointer reset", r, 0);
        put(3, 8'h00); // leave pointer at 3 then reset again
        do_reset(1'b1);
        wr(1'b0, 8'd3);
        rd(1'b1, r); chk("R2 strap=1 func reset", r, 8'h01);
        wr(1'b0, 8'd4);
        rd(1'b1, r); chk("R2 pprt reset", r, 8'h00);
        chk("R2 rate oe after strap", roe, 1);
        strap = 1'b0;
        repeat (2) @(negedge clk);
        wr(1'b0, 8'd3);
        rd(1'b1, r); chk("R2 strap ignored after reset", r, 8'h01);
        do_reset(1'b0);
        wr(1'b0, 8'd3);
        rd(1'b1, r); chk("R2 strap=0 func reset", r, 8'h00);

        // R1: pointer readback and unmapped pointers
        for (int p = 0; p < 256; p += 17) begin
            wr(1'b0, 8'(p));
            rd(1'b0, r); chk("R1 pointer readback", r, p);
        end
        put(3, 8'h5A);
        for (int p = 0; p < 16; p++) begin
            if (p == 3 || p == 4) continue;
            put(p, 8'hFF);
            rd(1'b1, r); chk("R1 unmapped reads zero", r, 0);
        end
        wr(1'b0, 8'd3);
        rd(1'b1, r); chk("R1 func untouched by other pointers", r, 8'h5A);
        wr(1'b0, 8'd4);
        rd(1'b1, r); chk("R1 pprt untouched by other pointers", r, 8'h00);

        // R3: parallel-port register mask
        for (int v = 0; v < 256; v += 5) begin
            put(4, 8'(v));
            rd(1'b1, r); chk("R3 pprt mask", r, v & 8'h13);
        end

        // R10: enable, version and access gate
        for (int v = 0; v < 4; v++) begin
            put(4, 8'(v));
            for (int a = 0; a < 2; a++) begin
                pacc = a[0];
                #1;
                chk("R10 par_en", paren, v & 1);
                chk("R10 par_ver", parver, (v >> 1) & 1);
                chk("R10 access gate", pacc_o, a & v & 1);
            end
        end
        pacc = 0;

        // R4..R9: sweep every pin-function value
        for (int f = 0; f < 256; f++) begin
            put(3, 8'(f));
            for (int k = 0; k < 32; k++) begin
                int v;
                int f0, f1, f2, f3, f4, f5, f6, f7;
                int es, em;
                v = (k * 73 + f * 29) % 2048;
                media = 2'(v); rate = 2'(v >> 2); idep = v[4];
                dsel = 2'(v >> 5); dmtr = 2'(v >> 7); sok = v[9]; ext = v[10];
                #1;
                f0 = f & 1; f1 = (f >> 1) & 1; f2 = (f >> 2) & 1; f3 = (f >> 3) & 1;
                f4 = (f >> 4) & 1; f5 = (f >> 5) & 1; f6 = (f >> 6) & 1; f7 = (f >> 7) & 1;
                chk("R4 media sense", msense, f0 ? 0 : int'(media));
                chk("R4 rate pins", rpin, f0 ? int'(rate) : 0);
                chk("R4 rate oe", roe, f0);
                chk("R5 ide dma", idma, f1);
                chk("R5 ide present", ipres, f1 ? 1 : int'(idep));
                chk("R6 pmux en", pen, f2);
                chk("R6 pmux oe", poe, f2 * (1 - f3));
                chk("R6 pmux pullup", ppu, f2 * (1 - f3));
                es = f4 ? (int'(dsel[0]) * 2 + int'(dsel[1])) : int'(dsel);
                em = f4 ? (int'(dmtr[0]) * 2 + int'(dmtr[1])) : int'(dmtr);
                chk("R7 drive select", osel, es);
                chk("R7 motor", omtr, em);
                chk("R8 zws pull", zlow, f5 * (1 - f6) * int'(sok));
                chk("R8 zws alt", zalt, f6);
                chk("R9 ready pull", rlow, (1 - f7) * int'(ext));
                chk("R9 ready alt", ralt, f7);
            end
        end

        // R11: pulse style
        put(4, 8'h01);
        @(negedge clk); evt = 1;
        @(negedge clk); evt = 0; chk("R11 pulse rises", irq, 1);
        @(negedge clk); chk("R11 pulse one cycle", irq, 0);
        @(negedge clk); evt = 1;
        @(negedge clk); chk("R11 pulse back-to-back a", irq, 1);
        @(negedge clk); evt = 0; chk("R11 pulse back-to-back b", irq, 1);
        @(negedge clk); chk("R11 pulse ends", irq, 0);

        // R11: level style
        put(4, 8'h10);
        @(negedge clk); evt = 1;
        @(negedge clk); evt = 0; chk("R11 level rises", irq, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); chk("R11 level held", irq, 1);
        end
        clr = 1;
        @(negedge clk); clr = 0; chk("R11 level cleared", irq, 0);
        @(negedge clk); chk("R11 level stays clear", irq, 0);
        evt = 1; clr = 1;
        @(negedge clk); evt = 0; clr = 0; chk("R11 event beats clear", irq, 1);
        @(negedge clk); chk("R11 level held after tie", irq, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule